// File: doc/BRIEF.md
# 64-bit Monotonic Event Counter

This block holds a 64-bit counter that never runs backwards unless software reloads it on purpose. The counter is reached through a simple register port as two 32-bit words, a low word and a high word. A separate mode register decides what a write to either word means. In load mode the written data replaces that word. In increment mode any write to either word adds one to the whole 64-bit value, and the data is ignored.

When an increment carries out of the top bit, an overflow flag sets. From then on the counter reads as zero and further increments leave it at zero. Only a successful load-mode write or reset clears the flag. Three lock inputs block writes to the mode register, the low word and the high word. An interrupt line reports the overflow flag when its enable bit is set.

Top module: `mono_counter64`

## Requirements
- R1: After reset, both counter words, the status word, the mode register and the interrupt enable register read 0, and `irq` is 0.
- R2: In load mode (mode register bit 4 = 0), a write to the low word (offset 0x28) that is not locked sets the low word to the written data and leaves the high word unchanged.
- R3: In load mode, a write to the high word (offset 0x2C) that is not locked sets the high word to the written data and leaves the low word unchanged.
- R4: In increment mode (mode register bit 4 = 1), a write that is not locked to either word adds one to the full 64-bit value. The carry goes from the low word into the high word, and the written data has no effect.
- R5: An increment from all ones sets the overflow flag (status word bit 3, offset 0x30). Both words then read 0, and later increments leave them at 0 while the flag stays set.
- R6: The overflow flag clears only on reset or on a load-mode write to a word that is not locked. Writes that are ignored leave it set.
- R7: While `lock_lo` is 1, writes to the low word are ignored in both modes. While `lock_hi` is 1, writes to the high word are ignored in both modes.
- R8: While `lock_mode` is 1, writes to the mode register (offset 0x20) are ignored.
- R9: The interrupt enable register (offset 0x34) keeps bit 3. `irq` is 1 exactly when that bit and the overflow flag are both 1.
- R10: The mode register reads back only bit 4, and the interrupt enable register reads back only bit 3. All other bits read 0, and any unmapped offset reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | ADDR_W | Write byte offset |
| wr_data | input | WORD_W | Write data |
| rd_addr | input | ADDR_W | Read byte offset |
| rd_data | output | WORD_W | Read data, combinational from `rd_addr` |
| lock_mode | input | 1 | Blocks writes to the mode register |
| lock_lo | input | 1 | Blocks writes to the low counter word |
| lock_hi | input | 1 | Blocks writes to the high counter word |
| irq | output | 1 | Overflow interrupt |

## Verification
A wrong counter value, a lost carry or a wrong mode bit shows up in the counter words on the first read after the write that caused it, because reads are combinational from state that is updated at the write edge. A flag that sets or clears wrongly shows up at once in the status word and on `irq`. Its side effect also shows up: the counter is forced to read zero. The directed scenarios cover carry across the word boundary, the wrap from all ones, the hold at zero while the flag is set, and locked writes that must not clear the flag.

// File: rtl/mono_counter64_pkg.sv
package mono_counter64_pkg;

    // Register byte offsets
    localparam int unsigned OFF_MODE   = 'h20;
    localparam int unsigned OFF_CNT_LO = 'h28;
    localparam int unsigned OFF_CNT_HI = 'h2C;
    localparam int unsigned OFF_STATUS = 'h30;
    localparam int unsigned OFF_IRQEN  = 'h34;

    // Bit positions that software decodes
    localparam int unsigned MODE_BIT   = 4;
    localparam int unsigned OVF_BIT    = 3;
    localparam int unsigned IRQEN_BIT  = 3;

    typedef enum logic {
        WR_LOAD = 1'b0,
        WR_INCR = 1'b1
    } wr_mode_e;

    typedef struct packed {
        logic ld_lo;
        logic ld_hi;
        logic inc;
        logic set_mode;
        logic set_ie;
    } wr_cmd_t;

endpackage

// File: rtl/mono_counter64_decode.sv
module mono_counter64_decode
    import mono_counter64_pkg::*;
#(
    parameter int unsigned ADDR_W = 12
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  wr_mode_e          mode,
    input  logic              lock_mode,
    input  logic              lock_lo,
    input  logic              lock_hi,
    output wr_cmd_t           cmd
);
    logic hit_lo, hit_hi;

    always_comb begin
        hit_lo = wr_en && (wr_addr == ADDR_W'(OFF_CNT_LO)) && !lock_lo;
        hit_hi = wr_en && (wr_addr == ADDR_W'(OFF_CNT_HI)) && !lock_hi;
        cmd.ld_lo    = hit_lo && (mode == WR_LOAD);
        cmd.ld_hi    = hit_hi && (mode == WR_LOAD);
        cmd.inc      = (hit_lo || hit_hi) && (mode == WR_INCR);
        cmd.set_mode = wr_en && (wr_addr == ADDR_W'(OFF_MODE)) && !lock_mode;
        cmd.set_ie   = wr_en && (wr_addr == ADDR_W'(OFF_IRQEN));
    end
endmodule

// File: rtl/mono_counter64_core.sv
module mono_counter64_core
    import mono_counter64_pkg::*;
#(
    parameter int unsigned WORD_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  wr_cmd_t             cmd,
    input  logic [WORD_W-1:0]   wr_data,
    output logic [2*WORD_W-1:0] cnt_q,
    output logic                ovf_q
);
    localparam int unsigned CNT_W = 2 * WORD_W;

    logic [CNT_W:0] sum;

    always_comb sum = {1'b0, cnt_q} + (CNT_W+1)'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else if (cmd.ld_lo) begin
            cnt_q[WORD_W-1:0] <= wr_data;
            ovf_q             <= 1'b0;
        end else if (cmd.ld_hi) begin
            cnt_q[CNT_W-1:WORD_W] <= wr_data;
            ovf_q                 <= 1'b0;
        end else if (cmd.inc && !ovf_q) begin
            cnt_q <= sum[CNT_W-1:0];
            if (sum[CNT_W]) ovf_q <= 1'b1;
        end
    end
endmodule

// File: rtl/mono_counter64_ctrl.sv
module mono_counter64_ctrl
    import mono_counter64_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  wr_cmd_t  cmd,
    input  logic     mode_bit,
    input  logic     ie_bit,
    output wr_mode_e mode_q,
    output logic     ie_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= WR_LOAD;
            ie_q   <= 1'b0;
        end else begin
            if (cmd.set_mode) mode_q <= mode_bit ? WR_INCR : WR_LOAD;
            if (cmd.set_ie)   ie_q   <= ie_bit;
        end
    end
endmodule

// File: rtl/mono_counter64_rdmux.sv
module mono_counter64_rdmux
    import mono_counter64_pkg::*;
#(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned ADDR_W = 12
) (
    input  logic [ADDR_W-1:0]   rd_addr,
    input  logic [2*WORD_W-1:0] cnt_q,
    input  logic                ovf_q,
    input  wr_mode_e            mode_q,
    input  logic                ie_q,
    output logic [WORD_W-1:0]   rd_data
);
    logic [2*WORD_W-1:0] cnt_vis;

    always_comb begin
        cnt_vis = ovf_q ? '0 : cnt_q;
        rd_data = '0;
        if (rd_addr == ADDR_W'(OFF_CNT_LO))
            rd_data = cnt_vis[WORD_W-1:0];
        else if (rd_addr == ADDR_W'(OFF_CNT_HI))
            rd_data = cnt_vis[2*WORD_W-1:WORD_W];
        else if (rd_addr == ADDR_W'(OFF_MODE))
            rd_data[MODE_BIT] = (mode_q == WR_INCR);
        else if (rd_addr == ADDR_W'(OFF_STATUS))
            rd_data[OVF_BIT] = ovf_q;
        else if (rd_addr == ADDR_W'(OFF_IRQEN))
            rd_data[IRQEN_BIT] = ie_q;
    end
endmodule

// File: rtl/mono_counter64.sv
module mono_counter64
    import mono_counter64_pkg::*;
#(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data,
    input  logic              lock_mode,
    input  logic              lock_lo,
    input  logic              lock_hi,
    output logic              irq
);
    localparam int unsigned CNT_W = 2 * WORD_W;

    wr_cmd_t          cmd;
    wr_mode_e         mode_q;
    logic             ie_q;
    logic [CNT_W-1:0] cnt_q;
    logic             ovf_q;

    mono_counter64_decode #(.ADDR_W(ADDR_W)) u_dec (
        .wr_en(wr_en), .wr_addr(wr_addr), .mode(mode_q),
        .lock_mode(lock_mode), .lock_lo(lock_lo), .lock_hi(lock_hi),
        .cmd(cmd)
    );

    mono_counter64_core #(.WORD_W(WORD_W)) u_core (
        .clk(clk), .rst(rst), .cmd(cmd), .wr_data(wr_data),
        .cnt_q(cnt_q), .ovf_q(ovf_q)
    );

    mono_counter64_ctrl u_ctrl (
        .clk(clk), .rst(rst), .cmd(cmd),
        .mode_bit(wr_data[MODE_BIT]), .ie_bit(wr_data[IRQEN_BIT]),
        .mode_q(mode_q), .ie_q(ie_q)
    );

    mono_counter64_rdmux #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_rd (
        .rd_addr(rd_addr), .cnt_q(cnt_q), .ovf_q(ovf_q),
        .mode_q(mode_q), .ie_q(ie_q), .rd_data(rd_data)
    );

    always_comb irq = ovf_q && ie_q;
endmodule

// File: rtl/mono_counter64_chk.sv
module mono_counter64_chk
    import mono_counter64_pkg::*;
#(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned ADDR_W = 12
) (
    input logic                clk,
    input logic                rst,
    input logic                wr_en,
    input logic [ADDR_W-1:0]   wr_addr,
    input logic [WORD_W-1:0]   wr_data,
    input logic                lock_mode,
    input logic                lock_lo,
    input logic                lock_hi,
    input logic                irq,
    input logic [2*WORD_W-1:0] cnt_q,
    input logic                ovf_q,
    input wr_mode_e            mode_q
);
    localparam int unsigned CNT_W = 2 * WORD_W;

    logic to_lo, to_hi, to_mode, load_ok, inc_ok;
    always_comb begin
        to_lo   = wr_en && (wr_addr == ADDR_W'(OFF_CNT_LO));
        to_hi   = wr_en && (wr_addr == ADDR_W'(OFF_CNT_HI));
        to_mode = wr_en && (wr_addr == ADDR_W'(OFF_MODE));
        load_ok = (mode_q == WR_LOAD) && ((to_lo && !lock_lo) || (to_hi && !lock_hi));
        inc_ok  = (mode_q == WR_INCR) && ((to_lo && !lock_lo) || (to_hi && !lock_hi));
    end

    AST_LOAD_LO: assert property (@(posedge clk) disable iff (rst)
        (load_ok && to_lo) |=> cnt_q[WORD_W-1:0] == $past(wr_data));        // R2
    AST_INC_STEP: assert property (@(posedge clk) disable iff (rst)
        (inc_ok && !ovf_q && !(&cnt_q)) |=> cnt_q == $past(cnt_q) + CNT_W'(1)); // R4
    AST_WRAP_SETS: assert property (@(posedge clk) disable iff (rst)
        (inc_ok && (&cnt_q)) |=> ovf_q);                                     // R5
    AST_ZERO_HELD: assert property (@(posedge clk) disable iff (rst)
        ovf_q |-> cnt_q == '0);                                              // R5
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (ovf_q && !load_ok) |=> ovf_q);                                      // R6
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
        load_ok |=> !ovf_q);                                                 // R6
    AST_LOCK_LO: assert property (@(posedge clk) disable iff (rst)
        (to_lo && lock_lo) |=> $stable(cnt_q));                              // R7
    AST_LOCK_HI: assert property (@(posedge clk) disable iff (rst)
        (to_hi && lock_hi) |=> $stable(cnt_q));                              // R7
    AST_LOCK_MODE: assert property (@(posedge clk) disable iff (rst)
        (to_mode && lock_mode) |=> $stable(mode_q));                         // R8
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
        irq |-> ovf_q);                                                      // R9
endmodule

bind mono_counter64 mono_counter64_chk #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .lock_mode(lock_mode), .lock_lo(lock_lo), .lock_hi(lock_hi), .irq(irq),
    .cnt_q(cnt_q), .ovf_q(ovf_q), .mode_q(mode_q)
);

// File: tb/mono_counter64_test.sv
module mono_counter64_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 12;
    localparam logic [AW-1:0] A_MODE = 12'h020;
    localparam logic [AW-1:0] A_LO   = 12'h028;
    localparam logic [AW-1:0] A_HI   = 12'h02C;
    localparam logic [AW-1:0] A_STAT = 12'h030;
    localparam logic [AW-1:0] A_IE   = 12'h034;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [31:0]   wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [31:0]   rd_data;
    logic          lock_mode = 1'b0, lock_lo = 1'b0, lock_hi = 1'b0;
    logic          irq;

    int checks = 0;
    int errors = 0;

    mono_counter64 uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .lock_mode(lock_mode),
        .lock_lo(lock_lo), .lock_hi(lock_hi), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [AW-1:0] a, input logic [31:0] exp);
        rd_addr = a;
        #1;
        check(req, rd_data, exp);
    endtask

    task automatic t_reset;
        rd_check("R1 low", A_LO, 0);
        rd_check("R1 high", A_HI, 0);
        rd_check("R1 status", A_STAT, 0);
        rd_check("R1 mode", A_MODE, 0);
        rd_check("R1 irqen", A_IE, 0);
        check("R1 irq", {31'b0, irq}, 0);
    endtask

    task automatic t_load;
        wr(A_LO, 32'h1234_5678);
        wr(A_HI, 32'h9ABC_DEF0);
        rd_check("R2 low load", A_LO, 32'h1234_5678);
        rd_check("R3 high load", A_HI, 32'h9ABC_DEF0);
        wr(A_LO, 32'h0BAD_F00D);
        rd_check("R2 low reload", A_LO, 32'h0BAD_F00D);
        rd_check("R2 high untouched", A_HI, 32'h9ABC_DEF0);
        wr(A_HI, 32'h11);
        rd_check("R3 low untouched", A_LO, 32'h0BAD_F00D);
        rd_check("R3 high reload", A_HI, 32'h11);
    endtask

    task automatic t_incr;
        wr(A_LO, 32'hFFFF_FFFF);
        wr(A_HI, 32'h5);
        wr(A_MODE, 32'hFFFF_FFFF);
        rd_check("R10 mode readback", A_MODE, 32'h10);
        wr(A_LO, 32'hDEAD_BEEF);
        rd_check("R4 carry low", A_LO, 0);
        rd_check("R4 carry high", A_HI, 6);
        wr(A_HI, 32'h0);
        rd_check("R4 inc via high low", A_LO, 1);
        rd_check("R4 inc via high high", A_HI, 6);
    endtask

    task automatic t_overflow;
        wr(A_MODE, 0);
        wr(A_LO, 32'hFFFF_FFFF);
        wr(A_HI, 32'hFFFF_FFFF);
        rd_check("R5 no flag before wrap", A_STAT, 0);
        wr(A_MODE, 32'h10);
        wr(A_HI, 32'h123);
        rd_check("R5 flag set", A_STAT, 32'h8);
        rd_check("R5 low zero", A_LO, 0);
        rd_check("R5 high zero", A_HI, 0);
        check("R9 irq masked", {31'b0, irq}, 0);
        wr(A_LO, 32'h1);
        rd_check("R5 held at zero", A_LO, 0);
        rd_check("R6 flag kept on increment", A_STAT, 32'h8);
        wr(A_IE, 32'hFFFF_FFFF);
        rd_check("R10 irqen readback", A_IE, 32'h8);
        check("R9 irq asserted", {31'b0, irq}, 1);
    endtask

    task automatic t_flag_clear;
        lock_lo = 1'b1;
        wr(A_MODE, 0);
        wr(A_LO, 32'h5);
        rd_check("R6 locked load keeps flag", A_STAT, 32'h8);
        rd_check("R7 locked low ignored", A_LO, 0);
        lock_lo = 1'b0;
        wr(A_LO, 32'h5);
        rd_check("R6 load clears flag", A_STAT, 0);
        rd_check("R2 low after clear", A_LO, 32'h5);
        check("R9 irq drops", {31'b0, irq}, 0);
    endtask

    task automatic t_locks;
        wr(A_HI, 32'h22);
        lock_hi = 1'b1;
        wr(A_HI, 32'h77);
        rd_check("R7 locked high load", A_HI, 32'h22);
        wr(A_MODE, 32'h10);
        wr(A_HI, 32'h0);
        rd_check("R7 locked high increment", A_LO, 32'h5);
        lock_hi = 1'b0; lock_lo = 1'b1;
        wr(A_LO, 32'h0);
        rd_check("R7 locked low increment", A_LO, 32'h5);
        wr(A_HI, 32'h0);
        rd_check("R4 increment via open half", A_LO, 32'h6);
        lock_lo = 1'b0;
    endtask

    task automatic t_mode_lock;
        lock_mode = 1'b1;
        wr(A_MODE, 0);
        rd_check("R8 mode write ignored", A_MODE, 32'h10);
        wr(A_LO, 32'hABCD);
        rd_check("R8 still increments", A_LO, 32'h7);
        lock_mode = 1'b0;
        wr(A_MODE, 0);
        rd_check("R8 mode write after unlock", A_MODE, 0);
        rd_check("R10 unmapped", 12'h100, 0);
        rd_check("R10 status offset read", A_STAT, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_load();
        t_incr();
        t_overflow();
        t_flag_clear();
        t_locks();
        t_mode_lock();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule